// File: doc/BRIEF.md
# Serial Flash Busy Poller

This block sits on the host side of a serial flash link. It launches one self-timed program or erase operation and then waits for the device to finish. A request carries an opcode, a 24-bit address, a flag that says whether the address follows the opcode, a minimum chip-select idle time and a timeout limit. The block shifts the opcode and any address bytes out in SPI mode 0. It then releases chip select. That rising edge is what starts the device's internal timer.

After the launch the block issues status reads again and again. Each read is the status opcode followed by one byte clocked back from the device. Bit 7 of that byte is the ready flag, where 1 means ready. Bit 6 carries the outcome of the latest page-to-buffer compare. The block stops when the device reports ready, or when the timeout budget has been used up. It then pulses a completion strobe and keeps the final status byte, the compare bit and a timeout flag until the next completion.

Top module: `flash_busy_poller`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, and busy, done, timed_out, cmp_result and poll_status are all 0.
- R2: An accepted request produces a single chip-select-low frame. The frame carries req_opcode, followed by req_addr as bits 23:16, then 15:8, then 7:0 when req_has_addr is 1. Every byte goes MSB first, with spi_mosi stable across each rising spi_sclk edge.
- R3: Within a frame, every high level and every low level of spi_sclk lasts exactly SCLK_HALF clock cycles.
- R4: Before each status frame, spi_cs_n stays high for at least req_gap cycles, and at least 1 cycle, after the previous frame ends.
- R5: Each status frame has 16 rising spi_sclk edges. The first 8 carry opcode 8'hD7 on spi_mosi. The last 8 sample the status byte from spi_miso, MSB first.
- R6: When a status byte has bit 7 = 1, done is high for exactly one cycle. That cycle is the one after the cycle in which spi_cs_n rises at the end of that frame. timed_out is 0 in that cycle.
- R7: A status byte with bit 7 = 0 ends the operation with done and timed_out = 1 when at least req_limit cycles have passed between the launch rise of spi_cs_n and the rise that ends that status frame. A ready status wins over an expired limit.
- R8: The final status byte appears on poll_status, with its bit 6 on cmp_result. Both, together with timed_out, hold their values until the next completion.
- R9: busy is high from the cycle after a request is accepted until done. req_valid has no effect while busy is high, and busy never rises without req_valid.
- R10: spi_sclk is 0 whenever spi_cs_n is high, and spi_cs_n is high whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_opcode | input | 8 | Program or erase opcode |
| req_addr | input | 24 | Address sent after the opcode |
| req_has_addr | input | 1 | 1: send the three address bytes |
| req_gap | input | GAP_W | Minimum chip-select high cycles before each poll |
| req_limit | input | TMR_W | Timeout budget in clock cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| timed_out | output | 1 | Last operation ended on timeout |
| cmp_result | output | 1 | Bit 6 of the final status byte |
| poll_status | output | 8 | Final status byte |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench builds the block with SCLK_HALF = 2, GAP_W = 8 and TMR_W = 16. With that short serial clock, one poll frame takes 64 cycles. That keeps multi-poll operations brief, and it lets timeout limits of 0, 10 and 150 fall before, on or after particular polls. A ready-versus-expired tie and a timeout that lands on the third poll are therefore cheap to set up. A gap of 0 exercises the one-cycle minimum, and a gap of 5 exercises the counted wait.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_GAP,
        ST_POLL,
        ST_EVAL
    } fbp_state_e;

    localparam logic [7:0] POLL_OPCODE = 8'hD7;
    localparam int         READY_BIT   = 7;
    localparam int         CMP_BIT     = 6;

endpackage

// File: rtl/fbp_spi_byte.sv
module fbp_spi_byte #(
    parameter int HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       last_o,
    output logic [7:0] rx_o
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HW-1:0] HLOAD = HW'(HALF - 1);

    typedef struct packed {
        logic          active;
        logic          phase;
        logic [HW-1:0] hcnt;
        logic [2:0]    bidx;
        logic [7:0]    tx;
        logic [7:0]    rx;
    } eng_t;

    eng_t r_q, r_d;
    logic last;

    always_comb begin
        r_d  = r_q;
        last = r_q.active && r_q.phase && (r_q.hcnt == '0) && (r_q.bidx == 3'd0);
        if (r_q.active) begin
            if (r_q.hcnt != '0) begin
                r_d.hcnt = r_q.hcnt - HW'(1);
            end else if (!r_q.phase) begin
                r_d.phase = 1'b1;
                r_d.hcnt  = HLOAD;
                r_d.rx    = {r_q.rx[6:0], miso_i};
            end else if (r_q.bidx != 3'd0) begin
                r_d.phase = 1'b0;
                r_d.hcnt  = HLOAD;
                r_d.bidx  = r_q.bidx - 3'd1;
                r_d.tx    = {r_q.tx[6:0], 1'b0};
            end else begin
                r_d.active = 1'b0;
            end
        end
        if (start_i && (!r_q.active || last)) begin
            r_d.active = 1'b1;
            r_d.phase  = 1'b0;
            r_d.hcnt   = HLOAD;
            r_d.bidx   = 3'd7;
            r_d.tx     = tx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sclk_o = r_q.active & r_q.phase;
    assign mosi_o = r_q.active & r_q.tx[7];
    assign last_o = last;
    assign rx_o   = r_q.rx;
endmodule

// File: rtl/fbp_timer.sv
module fbp_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        if (load_i)              cnt_d = limit_i;
        else if (cnt_q != '0)    cnt_d = cnt_q - W'(1);
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/flash_busy_poller.sv
module flash_busy_poller
    import fbp_pkg::*;
#(
    parameter int SCLK_HALF = 4,
    parameter int GAP_W     = 8,
    parameter int TMR_W     = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_opcode,
    input  logic [23:0]      req_addr,
    input  logic             req_has_addr,
    input  logic [GAP_W-1:0] req_gap,
    input  logic [TMR_W-1:0] req_limit,
    output logic             busy,
    output logic             done,
    output logic             timed_out,
    output logic             cmp_result,
    output logic [7:0]       poll_status,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    typedef struct packed {
        fbp_state_e       state;
        logic             cs_n;
        logic [1:0]       idx;
        logic [7:0]       op;
        logic [23:0]      addr;
        logic             has_addr;
        logic [GAP_W-1:0] gap;
        logic [GAP_W-1:0] gap_cnt;
        logic [TMR_W-1:0] limit;
        logic [7:0]       status;
        logic [7:0]       res_status;
        logic             timed_out;
        logic             done;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        state:      ST_IDLE,
        cs_n:       1'b1,
        idx:        '0,
        op:         '0,
        addr:       '0,
        has_addr:   1'b0,
        gap:        '0,
        gap_cnt:    '0,
        limit:      '0,
        status:     '0,
        res_status: '0,
        timed_out:  1'b0,
        done:       1'b0
    };

    ctl_t r_q, r_d;

    logic       eng_start;
    logic [7:0] eng_tx;
    logic       eng_last;
    logic [7:0] eng_rx;
    logic       tmr_load;
    logic       tmr_expired;
    logic [1:0] last_idx;

    fbp_spi_byte #(.HALF(SCLK_HALF)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .tx_i    (eng_tx),
        .miso_i  (spi_miso),
        .sclk_o  (spi_sclk),
        .mosi_o  (spi_mosi),
        .last_o  (eng_last),
        .rx_o    (eng_rx)
    );

    fbp_timer #(.W(TMR_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .limit_i   (r_q.limit),
        .expired_o (tmr_expired)
    );

    function automatic logic [7:0] cmd_byte(input logic [1:0] i, input logic [7:0] op,
                                            input logic [23:0] a);
        case (i)
            2'd1:    return a[23:16];
            2'd2:    return a[15:8];
            2'd3:    return a[7:0];
            default: return op;
        endcase
    endfunction

    assign last_idx = r_q.has_addr ? 2'd3 : 2'd0;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        eng_start = 1'b0;
        eng_tx    = 8'h00;
        tmr_load  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.op       = req_opcode;
                    r_d.addr     = req_addr;
                    r_d.has_addr = req_has_addr;
                    r_d.gap      = req_gap;
                    r_d.limit    = req_limit;
                    r_d.idx      = 2'd0;
                    r_d.cs_n     = 1'b0;
                    r_d.state    = ST_CMD;
                    eng_start    = 1'b1;
                    eng_tx       = req_opcode;
                end
            end
            ST_CMD: begin
                if (eng_last) begin
                    if (r_q.idx == last_idx) begin
                        r_d.state   = ST_GAP;
                        r_d.cs_n    = 1'b1;
                        r_d.gap_cnt = r_q.gap;
                        tmr_load    = 1'b1;
                    end else begin
                        r_d.idx   = r_q.idx + 2'd1;
                        eng_start = 1'b1;
                        eng_tx    = cmd_byte(r_q.idx + 2'd1, r_q.op, r_q.addr);
                    end
                end
            end
            ST_GAP: begin
                if (r_q.gap_cnt <= GAP_W'(1)) begin
                    r_d.state = ST_POLL;
                    r_d.cs_n  = 1'b0;
                    r_d.idx   = 2'd0;
                    eng_start = 1'b1;
                    eng_tx    = POLL_OPCODE;
                end else begin
                    r_d.gap_cnt = r_q.gap_cnt - GAP_W'(1);
                end
            end
            ST_POLL: begin
                if (eng_last) begin
                    if (r_q.idx == 2'd0) begin
                        r_d.idx   = 2'd1;
                        eng_start = 1'b1;
                        eng_tx    = 8'h00;
                    end else begin
                        r_d.status = eng_rx;
                        r_d.cs_n   = 1'b1;
                        r_d.state  = ST_EVAL;
                    end
                end
            end
            ST_EVAL: begin
                if (r_q.status[READY_BIT] || tmr_expired) begin
                    r_d.state      = ST_IDLE;
                    r_d.done       = 1'b1;
                    r_d.timed_out  = !r_q.status[READY_BIT];
                    r_d.res_status = r_q.status;
                end else begin
                    r_d.state   = ST_GAP;
                    r_d.gap_cnt = r_q.gap;
                end
            end
            default: r_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTL_RESET;
        else        r_q <= r_d;
    end

    assign busy        = (r_q.state != ST_IDLE);
    assign done        = r_q.done;
    assign timed_out   = r_q.timed_out;
    assign poll_status = r_q.res_status;
    assign cmp_result  = r_q.res_status[CMP_BIT];
    assign spi_cs_n    = r_q.cs_n;
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic timed_out,
    input logic spi_cs_n,
    input logic spi_sclk
);
    assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    assert_idle_cs_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(spi_cs_n));

    assert_busy_ends_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_no_self_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> !busy);

    assert_flag_moves_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(timed_out));
endmodule

bind flash_busy_poller fbp_checker u_fbp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .timed_out (timed_out),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk)
);

// File: tb/flash_busy_poller_bench.sv
`timescale 1ns/1ps
module flash_busy_poller_bench;
    localparam int HALF  = 2;
    localparam int GAP_W = 8;
    localparam int TMR_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [7:0]       req_opcode = '0;
    logic [23:0]      req_addr = '0;
    logic             req_has_addr = 1'b0;
    logic [GAP_W-1:0] req_gap = '0;
    logic [TMR_W-1:0] req_limit = '0;
    logic             busy, done, timed_out, cmp_result;
    logic [7:0]       poll_status;
    logic             spi_sclk, spi_cs_n, spi_mosi;
    logic             spi_miso = 1'b0;

    always #4 clk = ~clk;

    flash_busy_poller #(.SCLK_HALF(HALF), .GAP_W(GAP_W), .TMR_W(TMR_W)) u_flash_busy_poller (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_addr(req_addr), .req_has_addr(req_has_addr), .req_gap(req_gap),
        .req_limit(req_limit), .busy(busy), .done(done), .timed_out(timed_out),
        .cmp_result(cmp_result), .poll_status(poll_status), .spi_sclk(spi_sclk),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // test configuration for the device model
    int  t_busy_polls = 0;
    bit  t_cmp = 0;

    // reference model state
    bit          m_busy = 0, m_accept_next = 0, launched = 0;
    bit          m_to = 0, pend_done = 0, pend_to = 0, e_done;
    logic [7:0]  m_stat = '0, pend_stat = '0, cur_stat = '0;
    logic [7:0]  m_op;
    logic [23:0] m_addr;
    bit          m_has;
    int          m_gap, m_limit;
    int          cyc = 0, launch = 0, last_end = 0, npoll = 0;
    int          bits = 0, hi_run = 0, lo_run = 0, gmin;
    logic [7:0]  cur = '0;
    logic [7:0]  frame[$];
    bit          cs_p = 1, sclk_p = 0;

    always @(posedge clk) begin
        if (rst_n && req_valid && !m_busy && !m_accept_next) begin
            m_accept_next = 1;
            m_op    = req_opcode;
            m_addr  = req_addr;
            m_has   = req_has_addr;
            m_gap   = int'(req_gap);
            m_limit = int'(req_limit);
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (m_accept_next) begin
            m_busy = 1; m_accept_next = 0; launched = 0; npoll = 0;
        end
        e_done = pend_done;
        if (pend_done) begin
            m_busy = 0; m_to = pend_to; m_stat = pend_stat; pend_done = 0;
        end
        if (rst_n) begin
            chk(busy == m_busy, "R9", "busy", busy, m_busy);
            chk(done == e_done, "R6", "done", done, e_done);
            chk(timed_out == m_to, "R7", "timed_out", timed_out, m_to);
            chk(poll_status == m_stat, "R8", "poll_status", poll_status, m_stat);
            chk(cmp_result == m_stat[6], "R8", "cmp_result", cmp_result, m_stat[6]);
            chk(!(spi_cs_n && spi_sclk), "R10", "sclk while deselected", spi_sclk, 0);
            chk(m_busy || spi_cs_n, "R10", "cs_n while idle", spi_cs_n, 1);

            if (!spi_cs_n && cs_p) begin
                bits = 0; cur = '0; frame.delete(); hi_run = 0; lo_run = 0;
                cur_stat = {(npoll >= t_busy_polls), t_cmp, 6'b001101};
                if (m_busy && launched) begin
                    gmin = (m_gap == 0) ? 1 : m_gap;
                    chk((cyc - last_end) >= gmin, "R4", "cs_n high cycles", cyc - last_end, gmin);
                end
            end
            if (!spi_cs_n) begin
                if (spi_sclk && !sclk_p) begin
                    chk(lo_run == HALF, "R3", "sclk low run", lo_run, HALF);
                    cur = {cur[6:0], spi_mosi};
                    bits++;
                    if (bits % 8 == 0) frame.push_back(cur);
                    if (bits >= 8 && bits < 16) spi_miso = cur_stat[15 - bits];
                    else                        spi_miso = 1'b0;
                    hi_run = 0;
                end
                if (!spi_sclk && sclk_p) begin
                    chk(hi_run == HALF, "R3", "sclk high run", hi_run, HALF);
                    lo_run = 0;
                end
                if (spi_sclk) hi_run++;
                else          lo_run++;
            end
            if (spi_cs_n && !cs_p) begin
                last_end = cyc;
                spi_miso = 1'b0;
                if (frame.size() > 0 && frame[0] == 8'hD7) begin
                    chk(bits == 16, "R5", "status frame bits", bits, 16);
                    chk(launched, "R5", "poll before launch", launched, 1);
                    npoll++;
                    if (cur_stat[7]) begin
                        pend_done = 1; pend_to = 0; pend_stat = cur_stat;
                    end else if ((cyc - launch) >= m_limit) begin
                        pend_done = 1; pend_to = 1; pend_stat = cur_stat;
                    end
                end else begin
                    chk(m_busy && !launched, "R9", "unexpected command frame", launched, 0);
                    chk(bits == (m_has ? 32 : 8), "R2", "command bits", bits, m_has ? 32 : 8);
                    if (frame.size() > 0)
                        chk(frame[0] == m_op, "R2", "opcode byte", frame[0], m_op);
                    if (m_has && frame.size() == 4) begin
                        chk(frame[1] == m_addr[23:16], "R2", "addr byte 1", frame[1], m_addr[23:16]);
                        chk(frame[2] == m_addr[15:8],  "R2", "addr byte 2", frame[2], m_addr[15:8]);
                        chk(frame[3] == m_addr[7:0],   "R2", "addr byte 3", frame[3], m_addr[7:0]);
                    end
                    launched = 1;
                    launch = cyc;
                end
            end
        end
        cs_p = spi_cs_n;
        sclk_p = spi_sclk;
    end

    task automatic run_op(input logic [7:0] op, input logic [23:0] addr, input bit has,
                          input int gap, input int limit, input int bpolls, input bit cmpv,
                          input bit poke);
        int guard = 0;
        t_busy_polls = bpolls;
        t_cmp = cmpv;
        @(negedge clk);
        req_valid = 1; req_opcode = op; req_addr = addr; req_has_addr = has;
        req_gap = GAP_W'(gap); req_limit = TMR_W'(limit);
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            repeat (20) @(negedge clk);
            req_valid = 1; req_opcode = 8'h55; req_addr = 24'hFFFFFF; req_has_addr = 0;
            @(negedge clk);
            req_valid = 0;
        end
        @(posedge clk);
        while (m_busy && guard < 50000) begin
            @(posedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(spi_cs_n == 1'b1, "R1", "cs_n in reset", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1", "sclk in reset", spi_sclk, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
        chk(timed_out == 1'b0 && poll_status == 8'h00, "R1", "results in reset",
            {timed_out, poll_status}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R5 R6: sector erase with address, three busy polls
        run_op(8'h7C, 24'h012345, 1, 5, 60000, 3, 0, 0);
        // R2 R4: opcode only, zero gap, ready at first poll
        run_op(8'h94, 24'h000000, 0, 0, 60000, 0, 0, 0);
        // R8: compare result set
        run_op(8'h60, 24'hA5C3F0, 1, 2, 60000, 2, 1, 0);
        // R7: short limit, timeout at first poll, compare bit reported
        run_op(8'h7C, 24'h00FF00, 1, 1, 10, 100, 1, 0);
        // R7: ready wins over expired limit
        run_op(8'h81, 24'h000000, 0, 1, 10, 0, 0, 0);
        // R7: zero limit
        run_op(8'h50, 24'h123456, 1, 4, 0, 1, 0, 0);
        // R7: timeout on a later poll
        run_op(8'h7C, 24'h00AA00, 1, 3, 150, 10, 1, 0);
        // R9: request while busy is ignored
        run_op(8'h83, 24'h3C3C3C, 1, 6, 60000, 4, 0, 1);
        // R8: held result and a plain completion afterwards
        run_op(8'h88, 24'h000102, 1, 0, 60000, 1, 1, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule